// File: doc/BRIEF.md
# DSI Transmitter Power-Up Sequencer

This block brings a DSI transmitter and its D-PHY out of power-down. It runs on a free-running reference clock. After a start request it waits until the DSI clocks report stable and the supply-detect flag is set. It then releases the link and peripheral resets together and enables the bandgap. After a timed gap it enables the LDO. After a second gap it issues a one-cycle strobe that loads the PHY timing and link configuration registers, and waits for that load to be acknowledged. It then releases the common PHY reset and holds off for more than a millisecond before it raises ready.

Every wait is derived from a clock-frequency parameter. The count is rounded up and then extended by one cycle, so each gap is strictly longer than its minimum.

The lane-capability field reported by the transmitter cannot be trusted while the PHY is still coming up. The sequencer therefore ignores the field until ready is high and captures it once, in the first ready cycle. It reduces the captured value to an effective lane count by taking the smaller of the decoded capability and the number of data lanes the board wires up.

Top module: `dsi_pwrup_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is low: both resets asserted, the bandgap and LDO off, no load strobe, common reset asserted, `ready_o` low, `lanes_vld_o` low and `lanes_o` zero.
- R2: After `start_i` is taken in idle, `link_rst_n_o` and `periph_rst_n_o` rise together. They rise only on the clock edge after a cycle in which both `clk_stable_i` and `supply_det_i` are high. `bgr_en_o` rises exactly one cycle later.
- R3: `ldo_en_o` rises exactly G cycles after `bgr_en_o`, where G = ceil(BGR_US·CLK_KHZ/1000)+1, which is strictly more than BGR_US microseconds.
- R4: `cfg_load_o` rises exactly ceil(LDO_US·CLK_KHZ/1000)+1 cycles after `ldo_en_o` and stays high for one cycle only. `cmn_rst_n_o` rises on the edge that samples `cfg_done_i` high after the strobe, and not before.
- R5: `ready_o` rises exactly ceil(FIN_US·CLK_KHZ/1000)+1 cycles after `cmn_rst_n_o`.
- R6: `lane_cap_i` is sampled only on the edge one cycle after `ready_o` rises, and `lanes_vld_o` rises on that edge. Values of the field before then, and any change after it, have no effect on `lanes_o`.
- R7: `lanes_o` equals min(`lane_cap_i`+1, `cfg_lanes_i`), where `lane_cap_i` is a 2-bit field and 0..3 means 1..4 lanes.
- R8: If `clk_stable_i` falls after the resets are released but before ready, every output returns low on the next edge. The block then stays idle until a new `start_i`.
- R9: Once `ready_o` is high it stays high, and `lanes_o` stays unchanged, until `rst`, even if `clk_stable_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Power-up request, taken in idle |
| clk_stable_i | input | 1 | DSI clocks report stable |
| supply_det_i | input | 1 | Supply-detect flag |
| cfg_done_i | input | 1 | Register load acknowledge |
| lane_cap_i | input | CAP_W | Raw lane-capability field (count minus one) |
| cfg_lanes_i | input | LANE_W | Number of data lanes wired on the board |
| link_rst_n_o | output | 1 | Link reset, low = held in reset |
| periph_rst_n_o | output | 1 | Peripheral reset, low = held in reset |
| bgr_en_o | output | 1 | Bandgap enable |
| ldo_en_o | output | 1 | LDO enable |
| cfg_load_o | output | 1 | One-cycle strobe to load timing and link registers |
| cmn_rst_n_o | output | 1 | Common PHY reset, low = held in reset |
| ready_o | output | 1 | Transmitter ready |
| lanes_o | output | LANE_W | Effective lane count |
| lanes_vld_o | output | 1 | `lanes_o` is valid |

## Verification
The assertions assume the following about the inputs:
- `cfg_lanes_i` is between 1 and 4 and is held steady around the capture edge.
- `cfg_done_i` is a single-cycle pulse that answers a load strobe.
- `clk_stable_i` falls only as a deliberate abort.

The stimulus keeps to these rules. It fixes the lane setting before each start. It answers each strobe with exactly one acknowledge after a chosen latency. It toggles the capability field between 0 and 3 on every cycle until ready, so that a capture made too early would show up. It drops `clk_stable_i` only mid-sequence, to test the abort, or after ready, to show that the drop is ignored there.

// File: rtl/dsi_pwrup_pkg.sv
package dsi_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_BGR,
    ST_WBGR,
    ST_WLDO,
    ST_WDONE,
    ST_WFIN,
    ST_RDY
  } seq_st_t;

  // cycles strictly longer than us microseconds at khz kilohertz
  function automatic int unsigned gap_cycles(input int unsigned us, input int unsigned khz);
    return (us * khz + 999) / 1000 + 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dsi_gap_timer.sv
module dsi_gap_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == lim_i);
endmodule

// File: rtl/dsi_lane_resolve.sv
module dsi_lane_resolve #(
  parameter int CAP_W  = 2,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [CAP_W-1:0]  cap_i,
  input  logic [LANE_W-1:0] cfg_i,
  output logic [LANE_W-1:0] lanes_o,
  output logic              vld_o
);
  logic [LANE_W-1:0] cap_lanes;
  logic [LANE_W-1:0] pick;

  always_comb begin
    cap_lanes = LANE_W'(cap_i) + 1'b1;
    pick      = (cap_lanes < cfg_i) ? cap_lanes : cfg_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lanes_o <= '0;
      vld_o   <= 1'b0;
    end else if (take_i && !vld_o) begin
      lanes_o <= pick;
      vld_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/dsi_pwrup_seq.sv
module dsi_pwrup_seq
  import dsi_pwrup_pkg::*;
#(
  parameter int CLK_KHZ = 100000,
  parameter int BGR_US  = 20,
  parameter int LDO_US  = 10,
  parameter int FIN_US  = 1000,
  parameter int CAP_W   = 2,
  parameter int LANE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              clk_stable_i,
  input  logic              supply_det_i,
  input  logic              cfg_done_i,
  input  logic [CAP_W-1:0]  lane_cap_i,
  input  logic [LANE_W-1:0] cfg_lanes_i,
  output logic              link_rst_n_o,
  output logic              periph_rst_n_o,
  output logic              bgr_en_o,
  output logic              ldo_en_o,
  output logic              cfg_load_o,
  output logic              cmn_rst_n_o,
  output logic              ready_o,
  output logic [LANE_W-1:0] lanes_o,
  output logic              lanes_vld_o
);
  localparam int unsigned BGR_CYC = gap_cycles(BGR_US, CLK_KHZ);
  localparam int unsigned LDO_CYC = gap_cycles(LDO_US, CLK_KHZ);
  localparam int unsigned FIN_CYC = gap_cycles(FIN_US, CLK_KHZ);
  localparam int unsigned MAX_CYC = max3(BGR_CYC, LDO_CYC, FIN_CYC);
  localparam int          TW      = $clog2(MAX_CYC + 1);

  seq_st_t       st_q;
  logic          tmr_clr;
  logic          tmr_hit;
  logic [TW-1:0] tmr_lim;
  logic          abortable;

  always_comb begin
    unique case (st_q)
      ST_WBGR: tmr_lim = TW'(BGR_CYC - 1);
      ST_WLDO: tmr_lim = TW'(LDO_CYC - 1);
      default: tmr_lim = TW'(FIN_CYC - 1);
    endcase
    tmr_clr   = (st_q == ST_BGR) ||
                (st_q == ST_WBGR && tmr_hit) ||
                (st_q == ST_WDONE && cfg_done_i);
    abortable = (st_q == ST_BGR) || (st_q == ST_WBGR) || (st_q == ST_WLDO) ||
                (st_q == ST_WDONE) || (st_q == ST_WFIN);
  end

  dsi_gap_timer #(.TW(TW)) tmr_i (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tmr_clr),
    .lim_i (tmr_lim),
    .hit_o (tmr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || (abortable && !clk_stable_i)) begin
      st_q           <= ST_IDLE;
      link_rst_n_o   <= 1'b0;
      periph_rst_n_o <= 1'b0;
      bgr_en_o       <= 1'b0;
      ldo_en_o       <= 1'b0;
      cfg_load_o     <= 1'b0;
      cmn_rst_n_o    <= 1'b0;
      ready_o        <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_ARM;
        ST_ARM: if (clk_stable_i && supply_det_i) begin
          link_rst_n_o   <= 1'b1;
          periph_rst_n_o <= 1'b1;
          st_q           <= ST_BGR;
        end
        ST_BGR: begin
          bgr_en_o <= 1'b1;
          st_q     <= ST_WBGR;
        end
        ST_WBGR: if (tmr_hit) begin
          ldo_en_o <= 1'b1;
          st_q     <= ST_WLDO;
        end
        ST_WLDO: if (tmr_hit) begin
          cfg_load_o <= 1'b1;
          st_q       <= ST_WDONE;
        end
        ST_WDONE: begin
          cfg_load_o <= 1'b0;
          if (cfg_done_i) begin
            cmn_rst_n_o <= 1'b1;
            st_q        <= ST_WFIN;
          end
        end
        ST_WFIN: if (tmr_hit) begin
          ready_o <= 1'b1;
          st_q    <= ST_RDY;
        end
        default: st_q <= ST_RDY;
      endcase
    end
  end

  dsi_lane_resolve #(.CAP_W(CAP_W), .LANE_W(LANE_W)) lanes_i (
    .clk     (clk),
    .rst     (rst),
    .take_i  (st_q == ST_RDY),
    .cap_i   (lane_cap_i),
    .cfg_i   (cfg_lanes_i),
    .lanes_o (lanes_o),
    .vld_o   (lanes_vld_o)
  );
endmodule

// File: rtl/dsi_pwrup_seq_chk.sv
module dsi_pwrup_seq_chk #(
  parameter int CLK_KHZ = 100000,
  parameter int BGR_US  = 20,
  parameter int LDO_US  = 10,
  parameter int FIN_US  = 1000,
  parameter int LANE_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_stable_i,
  input logic              supply_det_i,
  input logic [LANE_W-1:0] cfg_lanes_i,
  input logic              link_rst_n_o,
  input logic              periph_rst_n_o,
  input logic              bgr_en_o,
  input logic              ldo_en_o,
  input logic              cfg_load_o,
  input logic              cmn_rst_n_o,
  input logic              ready_o,
  input logic [LANE_W-1:0] lanes_o,
  input logic              lanes_vld_o
);
  localparam int BGR_FLOOR = (BGR_US * CLK_KHZ) / 1000;
  localparam int LDO_FLOOR = (LDO_US * CLK_KHZ) / 1000;
  localparam int FIN_FLOOR = (FIN_US * CLK_KHZ) / 1000;

  int bgr_age, ldo_age, cmn_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      bgr_age <= 0;
      ldo_age <= 0;
      cmn_age <= 0;
    end else begin
      bgr_age <= bgr_en_o    ? bgr_age + 1 : 0;
      ldo_age <= ldo_en_o    ? ldo_age + 1 : 0;
      cmn_age <= cmn_rst_n_o ? cmn_age + 1 : 0;
    end
  end

  AST_RST_ON_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(periph_rst_n_o) |-> $past(clk_stable_i && supply_det_i)); // R2
  AST_BGR_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ldo_en_o) |-> bgr_age > BGR_FLOOR); // R3
  AST_LDO_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_load_o) |-> ldo_age > LDO_FLOOR); // R4
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_load_o |=> !cfg_load_o); // R4
  AST_FIN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> cmn_age > FIN_FLOOR); // R5
  AST_VLD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    lanes_vld_o |-> ready_o); // R6
  AST_LANES_HELD: assert property (@(posedge clk) disable iff (rst)
    (lanes_vld_o && $past(lanes_vld_o)) |-> $stable(lanes_o)); // R6
  AST_LANES_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(lanes_vld_o) |-> (lanes_o != 0 && lanes_o <= $past(cfg_lanes_i))); // R7
  AST_ABORT_OFF: assert property (@(posedge clk) disable iff (rst)
    (bgr_en_o && !ready_o && !clk_stable_i) |=> (!bgr_en_o && !link_rst_n_o && !cmn_rst_n_o)); // R8
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o); // R9
endmodule

bind dsi_pwrup_seq dsi_pwrup_seq_chk #(
  .CLK_KHZ(CLK_KHZ), .BGR_US(BGR_US), .LDO_US(LDO_US), .FIN_US(FIN_US), .LANE_W(LANE_W)
) chk_i (
  .clk(clk), .rst(rst), .clk_stable_i(clk_stable_i), .supply_det_i(supply_det_i),
  .cfg_lanes_i(cfg_lanes_i), .link_rst_n_o(link_rst_n_o), .periph_rst_n_o(periph_rst_n_o),
  .bgr_en_o(bgr_en_o), .ldo_en_o(ldo_en_o), .cfg_load_o(cfg_load_o),
  .cmn_rst_n_o(cmn_rst_n_o), .ready_o(ready_o), .lanes_o(lanes_o), .lanes_vld_o(lanes_vld_o)
);

// File: tb/dsi_pwrup_seq_tb_top.sv
module dsi_pwrup_seq_tb_top;
  localparam int KHZ     = 1000;
  localparam int BGR_GAP = 21;   // ceil(20*1000/1000)+1
  localparam int LDO_GAP = 11;   // ceil(10*1000/1000)+1
  localparam int FIN_GAP = 1001; // ceil(1000*1000/1000)+1

  logic clk = 1'b0;
  logic rst, start_i, clk_stable_i, supply_det_i, cfg_done_i;
  logic [1:0] lane_cap_i;
  logic [2:0] cfg_lanes_i;
  logic link_rst_n_o, periph_rst_n_o, bgr_en_o, ldo_en_o, cfg_load_o, cmn_rst_n_o, ready_o;
  logic [2:0] lanes_o;
  logic lanes_vld_o;

  always #5 clk = ~clk;

  dsi_pwrup_seq #(.CLK_KHZ(KHZ)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .clk_stable_i(clk_stable_i),
    .supply_det_i(supply_det_i), .cfg_done_i(cfg_done_i), .lane_cap_i(lane_cap_i),
    .cfg_lanes_i(cfg_lanes_i), .link_rst_n_o(link_rst_n_o), .periph_rst_n_o(periph_rst_n_o),
    .bgr_en_o(bgr_en_o), .ldo_en_o(ldo_en_o), .cfg_load_o(cfg_load_o),
    .cmn_rst_n_o(cmn_rst_n_o), .ready_o(ready_o), .lanes_o(lanes_o), .lanes_vld_o(lanes_vld_o)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int    id;
    int    gap;
    int    val;
    string req;
  } exp_t;
  exp_t expq[$];

  // event ids: 0 link 1 periph 2 bgr 3 ldo 4 load 5 cmn 6 ready 7 lanes_vld
  logic [7:0] prv = '0;
  int cyc = 0;
  int last_evt = 0;

  always @(negedge clk) begin
    logic [7:0] cur;
    cur = {lanes_vld_o, ready_o, cmn_rst_n_o, cfg_load_o, ldo_en_o, bgr_en_o,
           periph_rst_n_o, link_rst_n_o};
    cyc++;
    if (!rst) begin
      for (int i = 0; i < 8; i++) begin
        if (cur[i] && !prv[i]) begin
          if (expq.size() == 0) begin
            check(1'b0, "R8", "unexpected rise id", i, -1);
          end else begin
            exp_t e;
            e = expq.pop_front();
            check(e.id == i, e.req, "event order id", i, e.id);
            if (e.gap >= 0) check(cyc - last_evt == e.gap, e.req, "gap cycles", cyc - last_evt, e.gap);
            if (e.val >= 0) check(int'(lanes_o) == e.val, e.req, "lane count", int'(lanes_o), e.val);
          end
          last_evt = cyc;
        end
      end
    end
    prv = cur;
  end

  // load acknowledge responder
  int done_lat = 0;
  initial begin
    cfg_done_i = 1'b0;
    forever begin
      @(negedge clk);
      if (cfg_load_o) begin
        check(1'b1, "R4", "strobe seen", 1, 1);
        repeat (done_lat) begin
          @(negedge clk);
          if (cfg_load_o) check(1'b0, "R4", "strobe longer than one cycle", 1, 0);
          if (cmn_rst_n_o) check(1'b0, "R4", "common reset before ack", 1, 0);
        end
        cfg_done_i = 1'b1;
        @(negedge clk);
        cfg_done_i = 1'b0;
      end
    end
  end

  // capability field is noise (0 or 3) until ready shows, then the intended value
  int cap_hold = 0;
  always @(negedge clk) begin
    if (ready_o) lane_cap_i = 2'(cap_hold);
    else         lane_cap_i = ($urandom % 2 != 0) ? 2'd3 : 2'd0;
  end

  task automatic push(input int id, input int gap, input int val, input string req);
    exp_t e;
    e.id = id; e.gap = gap; e.val = val; e.req = req;
    expq.push_back(e);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({link_rst_n_o, periph_rst_n_o, bgr_en_o, ldo_en_o, cfg_load_o, cmn_rst_n_o,
           ready_o, lanes_vld_o, lanes_o} == '0, "R1", "outputs in reset", 1, 0);
    rst = 1'b0;
    @(negedge clk);
    check({link_rst_n_o, bgr_en_o, ready_o, lanes_vld_o, lanes_o} == '0, "R1",
          "outputs after reset", int'(ready_o), 0);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_vld();
    for (int i = 0; i < 5000 && !lanes_vld_o; i++) @(negedge clk);
  endtask

  task automatic full_run(input int cap, input int cfg, input int lat, input bit give_start);
    int expl;
    expl = (cap + 1 < cfg) ? cap + 1 : cfg;
    cap_hold = cap; cfg_lanes_i = 3'(cfg); done_lat = lat;
    push(0, -1, -1, "R2"); push(1, 0, -1, "R2"); push(2, 1, -1, "R2");
    push(3, BGR_GAP, -1, "R3"); push(4, LDO_GAP, -1, "R4"); push(5, lat + 1, -1, "R4");
    push(6, FIN_GAP, -1, "R5"); push(7, 1, expl, "R7");
    if (give_start) pulse_start();
    wait_vld();
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R6", "pending events", expq.size(), 0);
    // R9 and R6: drop the clock flag and change the field after ready
    clk_stable_i = 1'b0;
    cap_hold = 3 - cap;
    repeat (6) @(negedge clk);
    check(ready_o == 1'b1, "R9", "ready after clock drop", int'(ready_o), 1);
    check(int'(lanes_o) == expl, "R6", "lanes held after field change", int'(lanes_o), expl);
    clk_stable_i = 1'b1;
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; clk_stable_i = 1'b0; supply_det_i = 1'b0;
    cfg_lanes_i = 3'd4;
    repeat (2) @(negedge clk);
    do_reset();

    // R2: gating on both flags
    supply_det_i = 1'b1;
    pulse_start();
    repeat (40) @(negedge clk);
    check(!link_rst_n_o && !periph_rst_n_o, "R2", "resets held without stable clock",
          int'(link_rst_n_o), 0);
    supply_det_i = 1'b0; clk_stable_i = 1'b1;
    repeat (40) @(negedge clk);
    check(!link_rst_n_o && !periph_rst_n_o, "R2", "resets held without supply detect",
          int'(periph_rst_n_o), 0);
    supply_det_i = 1'b1;
    full_run(1, 4, 0, 1'b0);

    do_reset();

    // R8: abort in the LDO wait
    cfg_lanes_i = 3'd4;
    push(0, -1, -1, "R2"); push(1, 0, -1, "R2"); push(2, 1, -1, "R2"); push(3, BGR_GAP, -1, "R3");
    pulse_start();
    for (int i = 0; i < 200 && !ldo_en_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    clk_stable_i = 1'b0;
    @(negedge clk);
    check({link_rst_n_o, periph_rst_n_o, bgr_en_o, ldo_en_o, cfg_load_o, cmn_rst_n_o,
           ready_o} == '0, "R8", "outputs after abort", int'(ldo_en_o), 0);
    clk_stable_i = 1'b1;
    repeat (30) @(negedge clk);
    check(!link_rst_n_o && !bgr_en_o, "R8", "idle until new start", int'(link_rst_n_o), 0);
    check(expq.size() == 0, "R8", "pending events", expq.size(), 0);

    full_run(3, 1, 7, 1'b1);

    do_reset();
    full_run(2, 4, 3, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule